// File: doc/BRIEF.md
# Trap Request Flags and Arbiter

This block collects hardware trap conditions for a small 16-bit processor core and decides which trap the core should take next. Every trap source owns one sticky request bit in a 16-bit flag word. A bit is set by a hardware event or by a software write of 1. It stays set until software writes 0 to it, and while it is set it keeps requesting a trap.

The sources are split into two classes. Class A holds the non-maskable interrupt and the two stack bound faults. Each class A source has its own vector, and the three are ranked against each other. Class B holds five instruction and bus faults that share one vector and one priority level. The core supplies the priority level of the routine that is running. The block raises a request only when the winning trap's level is strictly higher than that level, so a class A trap can preempt a class B routine.

The NMI pin is active low. It is synchronized through two flops and then edge-detected. The stack faults come from comparing each new stack pointer value against two limit inputs.

Top module: `trap_arbiter`

## Requirements
- R1: After reset, every flag reads 0 and `trap_req_o`, `trap_vec_o` and `trap_lvl_o` are 0.
- R2: The flag word has these bit positions: NMI at bit 15, stack overflow at bit 14, stack underflow at bit 13, undefined opcode at bit 7, protection fault at bit 3, odd operand access at bit 2, odd branch target at bit 1 and missing external bus at bit 0. All other bits read as 0, and writes to them have no effect.
- R3: The `evt_b_i` bits map to flags as follows: bit 0 to flag 0, bit 1 to flag 1, bit 2 to flag 2, bit 3 to flag 3 and bit 4 to flag 7. A pulse sets its flag at the next clock edge. With no write, a set flag stays set.
- R4: A write (`reg_wr_i` = 1) loads `reg_wdata_i` into the implemented flags at the next edge. Writing 1 has the same effect as a hardware set. A flag left at 1 keeps raising the trap.
- R5: When a hardware set and a software write of 0 reach the same flag in the same cycle, the flag ends up 1.
- R6: A falling edge on `nmi_ni` sets the NMI flag at the third rising clock edge after the pin goes low, and not before. Holding the pin low does not set the flag again after software clears it.
- R7: A stack pointer update (`sp_wr_i`) sets the overflow flag when the new value is unsigned-below `ovf_lim_i` and the previous update was not below that limit. Further updates that stay below the limit do not set the flag again.
- R8: A stack pointer update sets the underflow flag when the new value is unsigned-above `unf_lim_i` and the previous update was not above that limit. Further updates that stay above the limit do not set the flag again.
- R9: The winning trap is chosen in this order: NMI (vector 0x02), then stack overflow (0x04), then stack underflow (0x06), each at level 2. If no class A flag is set, any class B flag wins with the shared vector 0x0A at level 1.
- R10: Levels are encoded 0 (no routine), 1 (class B), 2 (class A) and 3 (reset). `trap_req_o` is 1 only when the winning level is above `cur_lvl_i`. While the request is 0, the vector and level outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| evt_b_i | input | 5 | Class B event pulses |
| nmi_ni | input | 1 | Active-low non-maskable interrupt pin |
| sp_i | input | 16 | New stack pointer value |
| sp_wr_i | input | 1 | Stack pointer update strobe |
| ovf_lim_i | input | 16 | Stack overflow limit |
| unf_lim_i | input | 16 | Stack underflow limit |
| cur_lvl_i | input | 2 | Priority level of the running routine |
| reg_wr_i | input | 1 | Flag word write strobe |
| reg_wdata_i | input | 16 | Flag word write data |
| reg_rdata_o | output | 16 | Flag word read data |
| trap_req_o | output | 1 | Trap request |
| trap_vec_o | output | 8 | Vector of the winning trap |
| trap_lvl_o | output | 2 | Priority level of the winning trap |

## Verification
A corrupted flag shows on `reg_rdata_o` at the first negative clock edge after the edge that stored it. The request, vector and level outputs are combinational from the flags, so a wrong winner or level also appears in that same cycle. Wrong state in the NMI synchronizer or in the stack bound history stays hidden until the next pin edge or stack update, and then shows as a missing or extra flag one edge later. The bench therefore checks every output port every cycle and drives many pin toggles and limit crossings.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int unsigned FLAG_W = 16;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned LVL_W  = 2;
    localparam int unsigned NUM_B  = 5;

    localparam int unsigned POS_NMI = 15;
    localparam int unsigned POS_SOV = 14;
    localparam int unsigned POS_SUN = 13;

    localparam logic [VEC_W-1:0] VEC_NMI = 8'h02;
    localparam logic [VEC_W-1:0] VEC_SOV = 8'h04;
    localparam logic [VEC_W-1:0] VEC_SUN = 8'h06;
    localparam logic [VEC_W-1:0] VEC_B   = 8'h0A;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE = 2'd0,
        LVL_B    = 2'd1,
        LVL_A    = 2'd2,
        LVL_RST  = 2'd3
    } lvl_e;

    // flag position of class B source k (read port layout)
    function automatic int unsigned b_pos(int unsigned k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 3;
            default: return 7;
        endcase
    endfunction

    function automatic logic [FLAG_W-1:0] impl_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        m[POS_NMI] = 1'b1;
        m[POS_SOV] = 1'b1;
        m[POS_SUN] = 1'b1;
        for (int unsigned k = 0; k < NUM_B; k++) m[b_pos(k)] = 1'b1;
        return m;
    endfunction

    localparam logic [FLAG_W-1:0] IMPL_MASK = impl_mask();
endpackage

// File: rtl/trap_nmi_edge.sv
module trap_nmi_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_ni};
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end

    assign fall_o = st_q.last & ~st_q.sync[STAGES-1];
endmodule

// File: rtl/trap_stack_mon.sv
module trap_stack_mon #(
    parameter int unsigned SP_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [SP_W-1:0] sp_i,
    input  logic            sp_wr_i,
    input  logic [SP_W-1:0] ovf_lim_i,
    input  logic [SP_W-1:0] unf_lim_i,
    output logic            ovf_evt_o,
    output logic            unf_evt_o
);
    typedef struct packed {
        logic below;
        logic above;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    below_now, above_now;

    always_comb begin
        below_now = sp_i < ovf_lim_i;
        above_now = sp_i > unf_lim_i;
        st_d      = st_q;
        ovf_evt_o = 1'b0;
        unf_evt_o = 1'b0;
        if (sp_wr_i) begin
            ovf_evt_o  = below_now & ~st_q.below;
            unf_evt_o  = above_now & ~st_q.above;
            st_d.below = below_now;
            st_d.above = above_now;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/trap_select.sv
module trap_select
    import trap_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [LVL_W-1:0]  cur_lvl_i,
    output logic              req_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [LVL_W-1:0]  lvl_o
);
    logic [NUM_B-1:0] b_hit;
    lvl_e             win_lvl;
    logic [VEC_W-1:0] win_vec;

    for (genvar k = 0; k < NUM_B; k++) begin : g_bhit
        assign b_hit[k] = flags_i[b_pos(k)];
    end

    always_comb begin
        win_lvl = LVL_NONE;
        win_vec = '0;
        if (flags_i[POS_NMI]) begin
            win_lvl = LVL_A;
            win_vec = VEC_NMI;
        end else if (flags_i[POS_SOV]) begin
            win_lvl = LVL_A;
            win_vec = VEC_SOV;
        end else if (flags_i[POS_SUN]) begin
            win_lvl = LVL_A;
            win_vec = VEC_SUN;
        end else if (|b_hit) begin
            win_lvl = LVL_B;
            win_vec = VEC_B;
        end
        req_o = win_lvl > cur_lvl_i;
        vec_o = req_o ? win_vec : '0;
        lvl_o = req_o ? win_lvl : '0;
    end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int unsigned SP_W        = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_B-1:0]  evt_b_i,
    input  logic              nmi_ni,
    input  logic [SP_W-1:0]   sp_i,
    input  logic              sp_wr_i,
    input  logic [SP_W-1:0]   ovf_lim_i,
    input  logic [SP_W-1:0]   unf_lim_i,
    input  logic [LVL_W-1:0]  cur_lvl_i,
    input  logic              reg_wr_i,
    input  logic [FLAG_W-1:0] reg_wdata_i,
    output logic [FLAG_W-1:0] reg_rdata_o,
    output logic              trap_req_o,
    output logic [VEC_W-1:0]  trap_vec_o,
    output logic [LVL_W-1:0]  trap_lvl_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_st_t;

    flag_st_t          st_d, st_q;
    logic              nmi_fall, ovf_evt, unf_evt;
    logic [FLAG_W-1:0] hw_set, b_set;

    trap_nmi_edge #(.STAGES(SYNC_STAGES)) u_nmi (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_ni (nmi_ni),
        .fall_o (nmi_fall)
    );

    trap_stack_mon #(.SP_W(SP_W)) u_stk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sp_i      (sp_i),
        .sp_wr_i   (sp_wr_i),
        .ovf_lim_i (ovf_lim_i),
        .unf_lim_i (unf_lim_i),
        .ovf_evt_o (ovf_evt),
        .unf_evt_o (unf_evt)
    );

    // scatter class B pulses onto their flag positions
    for (genvar p = 0; p < FLAG_W; p++) begin : g_bset
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int unsigned k = 0; k < NUM_B; k++)
                if (b_pos(k) == p) hit = hit | evt_b_i[k];
        end
        assign b_set[p] = hit;
    end

    always_comb begin
        hw_set          = b_set;
        hw_set[POS_NMI] = nmi_fall;
        hw_set[POS_SOV] = ovf_evt;
        hw_set[POS_SUN] = unf_evt;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr_i) st_d.flags = reg_wdata_i;
        // hardware set overrides a same-cycle software clear
        st_d.flags = (st_d.flags | hw_set) & IMPL_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign reg_rdata_o = st_q.flags;

    trap_select u_sel (
        .flags_i   (st_q.flags),
        .cur_lvl_i (cur_lvl_i),
        .req_o     (trap_req_o),
        .vec_o     (trap_vec_o),
        .lvl_o     (trap_lvl_o)
    );
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk
    import trap_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_B-1:0]  evt_b_i,
    input logic [LVL_W-1:0]  cur_lvl_i,
    input logic              reg_wr_i,
    input logic [FLAG_W-1:0] reg_wdata_i,
    input logic [FLAG_W-1:0] reg_rdata_o,
    input logic              trap_req_o,
    input logic [VEC_W-1:0]  trap_vec_o,
    input logic [LVL_W-1:0]  trap_lvl_o
);
    assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o & ~IMPL_MASK) == '0);

    assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !reg_wr_i |=> ((reg_rdata_o & $past(reg_rdata_o)) == $past(reg_rdata_o)));

    assert_bus_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_b_i[0] |=> reg_rdata_o[0]);

    assert_hw_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_b_i[4] && reg_wr_i && !reg_wdata_i[7]) |=> reg_rdata_o[7]);

    assert_nmi_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_req_o && reg_rdata_o[POS_NMI]) |-> trap_vec_o == VEC_NMI);

    assert_shared_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_req_o && reg_rdata_o[15:13] == 3'b000) |-> (trap_vec_o == VEC_B && trap_lvl_o == 2'd1));

    assert_lvl_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> trap_lvl_o > cur_lvl_i);

    assert_idle_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_req_o |-> (trap_vec_o == '0 && trap_lvl_o == '0));
endmodule

bind trap_arbiter trap_arbiter_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_b_i     (evt_b_i),
    .cur_lvl_i   (cur_lvl_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .trap_req_o  (trap_req_o),
    .trap_vec_o  (trap_vec_o),
    .trap_lvl_o  (trap_lvl_o)
);

// File: tb/sim_trap_arbiter.sv
module sim_trap_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  evt = '0;
    logic        nmi_n = 1'b1;
    logic [15:0] sp = 16'h4000;
    logic        sp_wr = 1'b0;
    logic [15:0] ovf_lim = 16'h1000;
    logic [15:0] unf_lim = 16'h8000;
    logic [1:0]  cur = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        req;
    logic [7:0]  vec;
    logic [1:0]  lvl;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    logic [15:0] m_flags = '0;
    logic m_s1 = 1'b1, m_s2 = 1'b1, m_last = 1'b1;
    logic m_below = 1'b0, m_above = 1'b0;

    always #4 clk = ~clk;

    trap_arbiter u0 (
        .clk_i(clk), .rst_ni(rst_n), .evt_b_i(evt), .nmi_ni(nmi_n),
        .sp_i(sp), .sp_wr_i(sp_wr), .ovf_lim_i(ovf_lim), .unf_lim_i(unf_lim),
        .cur_lvl_i(cur), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .trap_req_o(req), .trap_vec_o(vec), .trap_lvl_o(lvl)
    );

    function automatic logic [15:0] b_map(logic [4:0] e);
        return {8'h00, e[4], 3'b000, e[3:0]};
    endfunction

    // {req, vec, lvl} expected from the flag image and current level
    function automatic logic [10:0] exp_sel(logic [15:0] f, logic [1:0] c);
        logic [7:0] v;
        logic [1:0] l;
        if (f[15])      begin v = 8'h02; l = 2'd2; end
        else if (f[14]) begin v = 8'h04; l = 2'd2; end
        else if (f[13]) begin v = 8'h06; l = 2'd2; end
        else if ((f & 16'h008F) != 0) begin v = 8'h0A; l = 2'd1; end
        else begin v = 8'h00; l = 2'd0; end
        if (l > c) return {1'b1, v, l};
        return 11'd0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic fall, ovf, unf, b, a;
        fall = m_last & ~m_s2;
        m_last = m_s2; m_s2 = m_s1; m_s1 = nmi_n;
        ovf = 1'b0; unf = 1'b0;
        if (sp_wr) begin
            b = sp < ovf_lim; a = sp > unf_lim;
            ovf = b & ~m_below; unf = a & ~m_above;
            m_below = b; m_above = a;
        end
        if (wr) m_flags = wdata & 16'hE08F;
        m_flags = m_flags | b_map(evt) | {fall, ovf, unf, 13'd0};
    endtask

    // one cycle: inputs already driven at negedge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        evt = '0; wr = 1'b0; sp_wr = 1'b0;
        chk("R2 R3 R4 R5 R6 R7 R8 flag image", 32'(rdata), 32'(m_flags));
        chk("R9 R10 select", 32'({req, vec, lvl}), 32'(exp_sel(m_flags, cur)));
    endtask

    task automatic wr_flags(logic [15:0] d);
        wr = 1'b1; wdata = d; tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired act=%0d exp=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flags at reset", 32'(rdata), 32'h0);
        chk("R1 outputs at reset", 32'({req, vec, lvl}), 32'h0);
        rst_n = 1'b1;
        tick();

        // R2: only implemented bits take writes
        wr_flags(16'hFFFF);
        chk("R2 layout", 32'(rdata), 32'h0000E08F);
        chk("R9 NMI first", 32'(vec), 32'h02);
        wr_flags(16'h6000);
        chk("R9 overflow beats underflow", 32'(vec), 32'h04);
        cur = 2'd2; tick();
        chk("R10 class A gated at level 2", 32'(req), 32'h0);
        cur = 2'd0;
        wr_flags(16'h0000);

        // R4: software set acts as hardware set and persists
        wr_flags(16'h0001);
        chk("R4 sw set raises class B", 32'({req, vec, lvl}), 32'({1'b1, 8'h0A, 2'd1}));
        repeat (3) tick();
        chk("R4 flag kept until cleared", 32'(req), 32'h1);
        cur = 2'd1; tick();
        chk("R10 class B gated at level 1", 32'(req), 32'h0);
        cur = 2'd0;
        wr_flags(16'h0000);

        // R5: hardware set beats same-cycle clear
        evt = 5'b10000; wr = 1'b1; wdata = 16'h0000; tick();
        chk("R5 hw set wins", 32'(rdata), 32'h0080);
        wr_flags(16'h0000);

        // R6: NMI timing through synchronizer
        nmi_n = 1'b0; tick(); tick();
        chk("R6 not yet after two edges", 32'(rdata[15]), 32'h0);
        tick();
        chk("R6 set on third edge", 32'(rdata[15]), 32'h1);
        wr_flags(16'h0000);
        repeat (5) tick();
        chk("R6 held low does not re-set", 32'(rdata[15]), 32'h0);
        nmi_n = 1'b1; repeat (4) tick();

        // R7: overflow crossing only
        sp = 16'h0FF0; sp_wr = 1'b1; tick();
        chk("R7 overflow on crossing", 32'(rdata[14]), 32'h1);
        wr_flags(16'h0000);
        sp = 16'h0FE0; sp_wr = 1'b1; tick();
        chk("R7 no re-flag while below", 32'(rdata[14]), 32'h0);
        sp = 16'h2000; sp_wr = 1'b1; tick();
        sp = 16'h0F00; sp_wr = 1'b1; tick();
        chk("R7 flag after re-crossing", 32'(rdata[14]), 32'h1);
        wr_flags(16'h0000);

        // R8: underflow crossing only
        sp = 16'h8001; sp_wr = 1'b1; tick();
        chk("R8 underflow on crossing", 32'(rdata[13]), 32'h1);
        wr_flags(16'h0000);
        sp = 16'hF000; sp_wr = 1'b1; tick();
        chk("R8 no re-flag while above", 32'(rdata[13]), 32'h0);
        sp = 16'h8000; sp_wr = 1'b1; tick();
        chk("R8 at limit is not above", 32'(rdata[13]), 32'h0);
        sp = 16'h4000; sp_wr = 1'b1; tick();
        wr_flags(16'h0000);

        // R3 R9 R10: constrained random against the model
        for (int i = 0; i < 4000; i++) begin
            for (int k = 0; k < 5; k++) evt[k] = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 14) == 0) nmi_n = ~nmi_n;
            sp_wr = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 2))
                0:       sp = 16'(ovf_lim - 16'($urandom_range(0, 4)) + 16'd2);
                1:       sp = 16'(unf_lim + 16'($urandom_range(0, 4)) - 16'd2);
                default: sp = 16'($urandom_range(0, 65535));
            endcase
            wr = ($urandom_range(0, 11) == 0);
            wdata = ($urandom_range(0, 1) == 0) ? 16'h0000 : 16'($urandom_range(0, 65535));
            cur = 2'($urandom_range(0, 3));
            tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule